// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block sits between seven peripheral interrupt flags and an 8051-style core. It holds a global enable and per-source enables in two enable registers. Two priority registers pair up bit by bit to give each source group a 2-bit level. Every cycle it searches the enabled, pending sources for the one with the highest level. Ties at the same level go to the source that comes first in a fixed polling order.

When the winner's level is strictly above every level already being serviced, the controller raises a request to the core with that source's vector address. It holds the request and vector until the core acknowledges. The acknowledge marks the level as in service. A return-from-interrupt pulse later releases the highest level in service.

Source indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial 0, 5 low-voltage and 6 IIC. Input `src_req[i]` carries the pending flag of source i. The core's configuration write port selects a register with `cfg_sel`: 0 is enable 0, 1 is enable 1, 2 is priority low and 3 is priority high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all four registers read 00h, `irq_req` is 0 and `irq_vec` is 00h.
- R2: Only implemented bits are stored and read back; others read 0. Enable 0 holds bit 7 (global) and bits 4..0 (sources 4..0). Enable 1 holds bit 5 (IIC) and bit 4 (low-voltage). Each priority register holds bits 5..0. Writing FFh therefore reads back 9Fh, 30h, 3Fh and 3Fh.
- R3: While enable 0 bit 7 is 0, no request is raised whatever the flags and other enables.
- R4: A source whose own enable bit is 0 never raises a request.
- R5: The vector for sources 0..6 is 03h, 0Bh, 13h, 1Bh, 23h, 63h and 6Bh respectively.
- R6: A source's level is {priority-high bit g, priority-low bit g}, where g is the source's group; 11b is the highest level and 00b the lowest. The eligible source with the highest level wins.
- R7: Among eligible sources at the same level, the lowest source index wins.
- R8: Low-voltage and IIC both take their level from bit 5 of the priority registers. When both are pending at that level, low-voltage wins.
- R9: A request is raised only when the candidate's level is strictly greater than every level in service. A candidate at an equal or lower level waits.
- R10: A return pulse clears only the highest in-service level, leaving lower nested levels in service.
- R11: Once raised, `irq_req` and `irq_vec` stay unchanged until `irq_ack`. The acknowledge clears `irq_req` at the next edge and puts the request's level in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable 0, 1 enable 1, 2 priority low, 3 priority high |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 7 | Pending flags, bit i is source i |
| irq_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the requested source |

## Verification
A vector table applies each source alone to tie every index to its vector. It then applies all sources together at level 0 to expose the polling order, including the low-voltage versus IIC tie. Mixed levels show that a higher level beats an earlier polling position and that the high priority bit outweighs the low one. Masked patterns (global off, single enable off) separate the global gate from per-source gating. Directed sequences nest two levels, try equal-level and higher-level candidates against the in-service set, and retire levels one return at a time to show which level a return releases.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 7,
  parameter int NLVL = 4,
  parameter int DW   = 8,
  parameter int VW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic [NSRC-1:0] src_req,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  localparam int LW  = $clog2(NLVL);
  localparam int IW  = $clog2(NSRC);
  localparam int NGRP = 6;
  localparam logic [DW-1:0] EN0_MASK = DW'(8'h9F);
  localparam logic [DW-1:0] EN1_MASK = DW'(8'h30);
  localparam logic [DW-1:0] PRI_MASK = DW'((1 << NGRP) - 1);

  logic [DW-1:0] en0_q, en1_q, pr0_q, pr1_q;
  logic [NLVL-1:0] isr_q, isr_d;
  logic          req_q;
  logic [VW-1:0] vec_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [VW-1:0] vec_of(input int i);
    if (i < 5) return VW'(8'h03 + 8 * i);
    return VW'(8'h63 + 8 * (i - 5));
  endfunction

  wire glob = en0_q[7];
  wire [NSRC-1:0] src_en = {en1_q[5], en1_q[4], en0_q[4:0]};
  wire [NSRC-1:0] elig = src_req & src_en & {NSRC{glob}};

  logic [LW-1:0] src_lvl [NSRC];
  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    localparam int GRP = (g < 5) ? g : 5;
    assign src_lvl[g] = LW'({pr1_q[GRP], pr0_q[GRP]});
  end

  logic          cand_vld;
  logic [IW-1:0] cand_idx;
  logic [LW-1:0] cand_lvl;
  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    cand_lvl = '0;
    for (int l = NLVL - 1; l >= 0; l--)
      for (int i = 0; i < NSRC; i++)
        if (!cand_vld && elig[i] && src_lvl[i] == LW'(l)) begin
          cand_vld = 1'b1;
          cand_idx = IW'(i);
          cand_lvl = LW'(l);
        end
  end

  logic          isr_any;
  logic [LW-1:0] isr_top;
  always_comb begin
    isr_top = '0;
    for (int l = 0; l < NLVL; l++)
      if (isr_q[l]) isr_top = LW'(l);
  end
  assign isr_any = |isr_q;

  wire take = cand_vld && (!isr_any || cand_lvl > isr_top);

  always_comb begin
    isr_d = isr_q;
    if (irq_ret && isr_any) isr_d[isr_top] = 1'b0;
    if (req_q && irq_ack) isr_d[lvl_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0_q <= '0;
      en1_q <= '0;
      pr0_q <= '0;
      pr1_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: en0_q <= cfg_wdata & EN0_MASK;
        2'd1: en1_q <= cfg_wdata & EN1_MASK;
        2'd2: pr0_q <= cfg_wdata & PRI_MASK;
        default: pr1_q <= cfg_wdata & PRI_MASK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (req_q) begin
        if (irq_ack) req_q <= 1'b0;
      end else if (take) begin
        req_q <= 1'b1;
        vec_q <= vec_of(int'(cand_idx));
        lvl_q <= cand_lvl;
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0: cfg_rdata = en0_q;
      2'd1: cfg_rdata = en1_q;
      2'd2: cfg_rdata = pr0_q;
      default: cfg_rdata = pr1_q;
    endcase
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NLVL = 4,
  parameter int VW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic          irq_ack,
  input logic          irq_ret,
  input logic          glob_en,
  input logic [NLVL-1:0] isr,
  input logic [$clog2(NLVL)-1:0] req_lvl
);
  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req);

  // R3
  glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en && !irq_req |=> !irq_req);

  // R9
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (isr >> req_lvl) == '0);

  // R10
  ret_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret && !(irq_req && irq_ack) && isr != '0
      |=> $countones(isr) + 1 == $countones($past(isr)));

  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec inside {8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h63, 8'h6B});
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NLVL(NLVL), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .glob_en(en0_q[7]),
  .isr(isr_q), .req_lvl(lvl_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [6:0] src_req = '0;
  logic irq_ack = 1'b0;
  logic irq_ret = 1'b0;
  logic irq_req;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // {en0, en1, pri_lo, pri_hi, flags, expect_req, expect_vec}
  localparam logic [48:0] TBL [NV] = '{
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h01, 1'b1, 8'h03},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h02, 1'b1, 8'h0B},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h04, 1'b1, 8'h13},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h08, 1'b1, 8'h1B},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h10, 1'b1, 8'h23},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h20, 1'b1, 8'h63},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h40, 1'b1, 8'h6B},
    {8'h1F, 8'h30, 8'h00, 8'h00, 8'h7F, 1'b0, 8'h00},
    {8'h9E, 8'h30, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00},
    {8'h9F, 8'h10, 8'h00, 8'h00, 8'h40, 1'b0, 8'h00},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h7F, 1'b1, 8'h03},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h7E, 1'b1, 8'h0B},
    {8'h9F, 8'h30, 8'h00, 8'h00, 8'h60, 1'b1, 8'h63},
    {8'h9F, 8'h30, 8'h10, 8'h10, 8'h7F, 1'b1, 8'h23},
    {8'h9F, 8'h30, 8'h08, 8'h00, 8'h0F, 1'b1, 8'h1B},
    {8'h9F, 8'h30, 8'h08, 8'h02, 8'h0F, 1'b1, 8'h0B},
    {8'h9F, 8'h30, 8'h20, 8'h00, 8'h41, 1'b1, 8'h6B},
    {8'h9F, 8'h30, 8'h20, 8'h00, 8'h61, 1'b1, 8'h63},
    {8'h9F, 8'h20, 8'h20, 8'h00, 8'h61, 1'b1, 8'h6B}
  };
  // rows 0-6 R5, 7 R3, 8-9 R4, 10-12 R7, 13-15 R6, 16-18 R8

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ack_only();
    irq_ack = 1'b1; src_req = '0;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic ret_once();
    irq_ret = 1'b1;
    tick();
    irq_ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s);
      #1 check("R1 reg reset", cfg_rdata, 8'h00);
    end
    check("R1 req reset", {7'd0, irq_req}, 8'h00);
    check("R1 vec reset", irq_vec, 8'h00);
    rst_n = 1'b1;
    tick();

    // R2 implemented bits
    begin
      logic [7:0] exp_rb [4] = '{8'h9F, 8'h30, 8'h3F, 8'h3F};
      for (int s = 0; s < 4; s++) begin
        wr(2'(s), 8'hFF);
        cfg_sel = 2'(s);
        #1 check("R2 readback", cfg_rdata, exp_rb[s]);
        wr(2'(s), 8'h00);
      end
    end

    for (int k = 0; k < NV; k++) begin
      logic [7:0] e0, e1, p0, p1, rq, ev;
      logic ex;
      {e0, e1, p0, p1, rq, ex, ev} = TBL[k];
      wr(2'd0, e0); wr(2'd1, e1); wr(2'd2, p0); wr(2'd3, p1);
      src_req = rq[6:0];
      tick();
      check($sformatf("R3-R8 row %0d req", k), {7'd0, irq_req}, {7'd0, ex});
      if (ex) check($sformatf("R5 row %0d vec", k), irq_vec, ev);
      src_req = '0;
      if (irq_req) begin
        ack_only();
        check("R11 ack clears req", {7'd0, irq_req}, 8'h00);
        ret_once();
      end
    end

    // R11 hold until acknowledge
    wr(2'd0, 8'h9F); wr(2'd1, 8'h30); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    src_req = 7'h02;
    tick();
    check("R11 raised vec", irq_vec, 8'h0B);
    src_req = 7'h03;
    tick(); tick();
    check("R11 vec held", irq_vec, 8'h0B);
    src_req = '0;
    tick();
    check("R11 req held", {7'd0, irq_req}, 8'h01);
    ack_only();
    check("R11 req dropped", {7'd0, irq_req}, 8'h00);
    ret_once();

    // R9 / R10 nesting: ext0, timer0 at level 1, serial at level 2
    wr(2'd2, 8'h03); wr(2'd3, 8'h10);
    src_req = 7'h01;
    tick();
    check("R9 first vec", irq_vec, 8'h03);
    ack_only();
    src_req = 7'h02;
    tick(); tick();
    check("R9 equal level blocked", {7'd0, irq_req}, 8'h00);
    src_req = 7'h12;
    tick();
    check("R9 higher preempts req", {7'd0, irq_req}, 8'h01);
    check("R9 higher preempts vec", irq_vec, 8'h23);
    ack_only();
    ret_once();
    src_req = 7'h02;
    tick(); tick();
    check("R10 lower level kept", {7'd0, irq_req}, 8'h00);
    src_req = 7'h12;
    tick();
    check("R10 upper level released", irq_vec, 8'h23);
    check("R10 upper level req", {7'd0, irq_req}, 8'h01);
    ack_only();
    ret_once();
    ret_once();
    src_req = 7'h02;
    tick();
    check("R10 all released vec", irq_vec, 8'h0B);
    ack_only();
    ret_once();

    finish_run();
  end
endmodule